// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits behind an SPI byte shifter in a serial NOR flash slave. Each transfer hands it one received byte, and it answers with one response byte. A separate chip-select strobe marks the start of a new command frame. The first byte of a frame is decoded as an opcode. Depending on that opcode, the sequencer then gathers address and dummy bytes, streams array data, accepts program data, or plays back a register value.

The sequencer keeps the write-enable latch. It builds the status byte and the identification bytes itself. Array work is passed to a separate array engine through three paths: a one-cycle erase request carrying a kind and an address, a one-cycle program request carrying an address and a data byte, and a combinational read port (address out, data in).

Dual and quad read and program opcodes are accepted, but their data still moves on the single byte stream. The number of dummy bytes for the dual and quad I/O reads depends on the manufacturer ID parameter.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the response byte is 0x00, the sequencer is idle and the write-enable latch is clear, so a status read returns 0x00.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns one status byte with the latch in bit 1 and all other bits zero. The byte after that status byte is decoded as a new opcode.
- R3: Opcode 0x9F returns the manufacturer byte, then the two device bytes most significant first. When the extended ID parameter is nonzero, two more extended bytes follow (high byte first). After the last ID byte the sequencer is idle again.
- R4: Opcode 0x03 collects a 24-bit address, high byte first. Each following transfer returns `rd_data` for the current address and then advances the address, wrapping from DEV_SIZE-1 to 0.
- R5: Opcodes 0x0B, 0x3B and 0x6B collect four bytes (three address bytes and one dummy) before the first data byte.
- R6: Opcode 0xBB collects 4 bytes when MFR_ID is 0xEF or 0x01, and 5 bytes otherwise. Opcode 0xEB collects 6 bytes for those IDs and 8 bytes otherwise.
- R7: Opcodes 0x02, 0xA2 and 0x32 collect an address. Each following byte raises `prog_req` for one cycle with `prog_addr` and `prog_data`, and the address then increments by one.
- R8: Opcodes 0x20, 0xD8 and 0x52 collect an address. If the latch is set at completion, they raise `erase_req` for one cycle with `erase_addr` and with `erase_kind` 0 (4 KiB), 2 (sector) or 1 (32 KiB) respectively. If the latch is clear, no request is raised.
- R9: Opcode 0xC7 raises `erase_req` in the transfer that carries it, with kind 3 and address 0, but only while the latch is set.
- R10: Opcode 0x01 is ignored when the latch is clear, and the next byte is decoded as an opcode. When the latch is set, it collects one byte, then clears the latch and returns to idle.
- R11: `cs_start` forces idle and clears the byte counters. A byte arriving in the same cycle as `cs_start` is decoded as an opcode.
- R12: The response byte is 0x00 in every state other than array read and register playback. Opcode 0x00 and unknown opcodes leave the sequencer idle.
- R13: The response and both request outputs change only in the cycle after a transfer. The response holds its value between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_start | input | 1 | Chip select has just been asserted; starts a new frame |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Response byte for the latest transfer |
| rd_addr | output | 24 | Array read address (current address) |
| rd_data | input | 8 | Array data at `rd_addr`, combinational |
| erase_req | output | 1 | One-cycle erase request |
| erase_kind | output | 2 | 0=4 KiB, 1=32 KiB, 2=sector, 3=whole device |
| erase_addr | output | 24 | Erase start address |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 24 | Program byte address |
| prog_data | output | 8 | Program byte value |

## Verification
Every result is due exactly one clock edge after the transfer that produces it. This covers the response byte, an erase or program pulse, and a change of state. The bench presents each byte for one cycle starting at a falling edge and reads every output at the next falling edge. That point falls after the single register stage and before the next byte can change anything. Array read data comes from a bench function of `rd_addr`, so each read byte is due one transfer after the byte that moved the address there. Two instances that differ only in their ID parameters receive the same stream, and this exposes the dummy-count difference by which transfer first carries array data.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int ADDR_W     = 24;
    localparam int ADDR_BYTES = 3;
    localparam int CNT_W      = 4;
    localparam int POS_W      = 3;

    localparam logic [7:0] OP_NOP    = 8'h00;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_PROG1  = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_ER4K   = 8'h20;
    localparam logic [7:0] OP_PROG4  = 8'h32;
    localparam logic [7:0] OP_DOREAD = 8'h3B;
    localparam logic [7:0] OP_ER32K  = 8'h52;
    localparam logic [7:0] OP_QOREAD = 8'h6B;
    localparam logic [7:0] OP_RDID   = 8'h9F;
    localparam logic [7:0] OP_PROG2  = 8'hA2;
    localparam logic [7:0] OP_DIREAD = 8'hBB;
    localparam logic [7:0] OP_BULK   = 8'hC7;
    localparam logic [7:0] OP_ERSEC  = 8'hD8;
    localparam logic [7:0] OP_QIREAD = 8'hEB;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PROG    = 3'd1,
        ST_READ    = 3'd2,
        ST_COLLECT = 3'd3,
        ST_RETURN  = 3'd4
    } seq_state_e;

    typedef enum logic [3:0] {
        OC_NONE  = 4'd0,
        OC_WREN  = 4'd1,
        OC_WRDI  = 4'd2,
        OC_RDSR  = 4'd3,
        OC_RDID  = 4'd4,
        OC_WRSR  = 4'd5,
        OC_BULK  = 4'd6,
        OC_READ  = 4'd7,
        OC_PROG  = 4'd8,
        OC_ERASE = 4'd9
    } op_class_e;

    typedef struct packed {
        seq_state_e        st;
        logic              wel;
        logic [7:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [POS_W-1:0]  pos;
        logic [7:0]        stat;
        logic [7:0]        tx;
        logic              er_req;
        logic [1:0]        er_kind;
        logic [ADDR_W-1:0] er_addr;
        logic              pg_req;
        logic [ADDR_W-1:0] pg_addr;
        logic [7:0]        pg_data;
    } seq_regs_t;

endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
    import flash_seq_pkg::*;
#(
    parameter logic [7:0] MFR_ID = 8'h20
) (
    input  logic [7:0]       op,
    output op_class_e        cls,
    output logic [CNT_W-1:0] need,
    output logic [1:0]       kind
);
    localparam logic SHORT_IO = (MFR_ID == 8'hEF) || (MFR_ID == 8'h01);
    localparam logic [CNT_W-1:0] DIO_NEED = SHORT_IO ? CNT_W'(4) : CNT_W'(5);
    localparam logic [CNT_W-1:0] QIO_NEED = SHORT_IO ? CNT_W'(6) : CNT_W'(8);

    always_comb begin
        cls  = OC_NONE;
        need = '0;
        kind = 2'd0;
        case (op)
            OP_WREN: cls = OC_WREN;
            OP_WRDI: cls = OC_WRDI;
            OP_RDSR: cls = OC_RDSR;
            OP_RDID: cls = OC_RDID;
            OP_WRSR: begin cls = OC_WRSR; need = CNT_W'(1); end
            OP_BULK: begin cls = OC_BULK; kind = 2'd3; end
            OP_READ: begin cls = OC_READ; need = CNT_W'(3); end
            OP_FREAD, OP_DOREAD, OP_QOREAD: begin
                cls  = OC_READ;
                need = CNT_W'(4);
            end
            OP_DIREAD: begin cls = OC_READ; need = DIO_NEED; end
            OP_QIREAD: begin cls = OC_READ; need = QIO_NEED; end
            OP_PROG1, OP_PROG2, OP_PROG4: begin
                cls  = OC_PROG;
                need = CNT_W'(3);
            end
            OP_ER4K:  begin cls = OC_ERASE; need = CNT_W'(3); kind = 2'd0; end
            OP_ER32K: begin cls = OC_ERASE; need = CNT_W'(3); kind = 2'd1; end
            OP_ERSEC: begin cls = OC_ERASE; need = CNT_W'(3); kind = 2'd2; end
            default: cls = OC_NONE;
        endcase
    end
endmodule

// File: rtl/flash_id_bytes.sv
module flash_id_bytes
    import flash_seq_pkg::*;
#(
    parameter logic [7:0]  MFR_ID = 8'h20,
    parameter logic [15:0] DEV_ID = 16'h2014,
    parameter logic [15:0] EXT_ID = 16'h0000
) (
    input  logic [POS_W-1:0] pos,
    output logic [7:0]       id_byte,
    output logic [POS_W-1:0] id_len
);
    generate
        if (EXT_ID != 16'h0000) begin : g_long
            assign id_len = POS_W'(5);
        end else begin : g_short
            assign id_len = POS_W'(3);
        end
    endgenerate

    always_comb begin
        case (pos)
            3'd0:    id_byte = MFR_ID;
            3'd1:    id_byte = DEV_ID[15:8];
            3'd2:    id_byte = DEV_ID[7:0];
            3'd3:    id_byte = EXT_ID[15:8];
            3'd4:    id_byte = EXT_ID[7:0];
            default: id_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/flash_addr_step.sv
module flash_addr_step
    import flash_seq_pkg::*;
#(
    parameter int DEV_SIZE = 1 << 20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] rd_next,
    output logic [ADDR_W-1:0] pg_next
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEV_SIZE - 1);

    assign pg_next = addr + ADDR_W'(1);

    generate
        if ((DEV_SIZE & (DEV_SIZE - 1)) == 0) begin : g_pow2
            assign rd_next = (addr + ADDR_W'(1)) & LAST;
        end else begin : g_cmp
            assign rd_next = (addr >= LAST) ? '0 : addr + ADDR_W'(1);
        end
    endgenerate
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int          DEV_SIZE = 1 << 20,
    parameter logic [7:0]  MFR_ID   = 8'h20,
    parameter logic [15:0] DEV_ID   = 16'h2014,
    parameter logic [15:0] EXT_ID   = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              erase_req,
    output logic [1:0]        erase_kind,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data
);
    seq_regs_t q, d;

    seq_state_e        base_st;
    logic [7:0]        op_sel;
    op_class_e         dec_cls;
    logic [CNT_W-1:0]  dec_need;
    logic [1:0]        dec_kind;
    logic [7:0]        id_byte;
    logic [POS_W-1:0]  id_len;
    logic [POS_W-1:0]  ret_len;
    logic [ADDR_W-1:0] rd_next;
    logic [ADDR_W-1:0] pg_next;
    logic [ADDR_W-1:0] addr_col;
    logic [CNT_W-1:0]  cnt_inc;
    logic [POS_W-1:0]  pos_inc;
    logic              wel_w;
    logic [2:0]        state_w;

    assign base_st = cs_start ? ST_IDLE : q.st;
    assign op_sel  = (base_st == ST_IDLE) ? rx_byte : q.op;

    flash_op_decode #(.MFR_ID(MFR_ID)) u_dec (
        .op   (op_sel),
        .cls  (dec_cls),
        .need (dec_need),
        .kind (dec_kind)
    );

    flash_id_bytes #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .EXT_ID(EXT_ID)) u_id (
        .pos     (q.pos),
        .id_byte (id_byte),
        .id_len  (id_len)
    );

    flash_addr_step #(.DEV_SIZE(DEV_SIZE)) u_step (
        .addr    (q.addr),
        .rd_next (rd_next),
        .pg_next (pg_next)
    );

    assign addr_col = (q.cnt < CNT_W'(ADDR_BYTES)) ? {q.addr[ADDR_W-9:0], rx_byte} : q.addr;
    assign cnt_inc  = q.cnt + CNT_W'(1);
    assign pos_inc  = q.pos + POS_W'(1);
    assign ret_len  = (q.op == OP_RDSR) ? POS_W'(1) : id_len;

    always_comb begin
        d        = q;
        d.er_req = 1'b0;
        d.pg_req = 1'b0;
        if (cs_start) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.pos = '0;
        end
        if (rx_valid) begin
            d.tx = 8'h00;
            case (base_st)
                ST_IDLE: begin
                    d.op  = rx_byte;
                    d.cnt = '0;
                    d.pos = '0;
                    case (dec_cls)
                        OC_WREN: d.wel = 1'b1;
                        OC_WRDI: d.wel = 1'b0;
                        OC_RDSR: begin
                            d.stat = {6'b0, q.wel, 1'b0};
                            d.st   = ST_RETURN;
                        end
                        OC_RDID: d.st = ST_RETURN;
                        OC_WRSR: if (q.wel) d.st = ST_COLLECT;
                        OC_BULK: if (q.wel) begin
                            d.er_req  = 1'b1;
                            d.er_kind = dec_kind;
                            d.er_addr = '0;
                        end
                        OC_READ, OC_PROG, OC_ERASE: d.st = ST_COLLECT;
                        default: d.st = ST_IDLE;
                    endcase
                end
                ST_COLLECT: begin
                    d.addr = addr_col;
                    d.cnt  = cnt_inc;
                    if (cnt_inc == dec_need) begin
                        d.st = ST_IDLE;
                        case (dec_cls)
                            OC_PROG: d.st = ST_PROG;
                            OC_READ: d.st = ST_READ;
                            OC_ERASE: if (q.wel) begin
                                d.er_req  = 1'b1;
                                d.er_kind = dec_kind;
                                d.er_addr = addr_col;
                            end
                            OC_WRSR: d.wel = 1'b0;
                            default: d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_RETURN: begin
                    d.tx = (q.op == OP_RDSR) ? q.stat : id_byte;
                    if (pos_inc == ret_len) begin
                        d.st  = ST_IDLE;
                        d.pos = '0;
                    end else begin
                        d.pos = pos_inc;
                    end
                end
                ST_READ: begin
                    d.tx   = rd_data;
                    d.addr = rd_next;
                end
                ST_PROG: begin
                    d.pg_req  = 1'b1;
                    d.pg_addr = q.addr;
                    d.pg_data = rx_byte;
                    d.addr    = pg_next;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_byte    = q.tx;
    assign rd_addr    = q.addr;
    assign erase_req  = q.er_req;
    assign erase_kind = q.er_kind;
    assign erase_addr = q.er_addr;
    assign prog_req   = q.pg_req;
    assign prog_addr  = q.pg_addr;
    assign prog_data  = q.pg_data;
    assign wel_w      = q.wel;
    assign state_w    = q.st;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
    import flash_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_start,
    input logic       rx_valid,
    input logic [7:0] tx_byte,
    input logic       erase_req,
    input logic       prog_req,
    input logic       wel,
    input logic [2:0] state
);
    assert_erase_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(wel));

    assert_prog_on_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(rx_valid));

    assert_tx_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(tx_byte));

    assert_cs_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_start && !rx_valid) |=> (state == 3'(ST_IDLE)));

    assert_one_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_req, prog_req}));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_start  (cs_start),
    .rx_valid  (rx_valid),
    .tx_byte   (tx_byte),
    .erase_req (erase_req),
    .prog_req  (prog_req),
    .wel       (wel_w),
    .state     (state_w)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_start = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    always #2 clk = ~clk;

    logic [7:0]  tx_a, tx_b, rdd_a, rdd_b, pd_a, pd_b;
    logic [23:0] ra_a, ra_b, ea_a, ea_b, pa_a, pa_b;
    logic        er_a, er_b, pr_a, pr_b;
    logic [1:0]  ek_a, ek_b;

    function automatic logic [7:0] mem(input logic [23:0] a);
        return a[7:0] ^ {4'h0, a[11:8]} ^ 8'h3C;
    endfunction
    assign rdd_a = mem(ra_a);
    assign rdd_b = mem(ra_b);

    flash_cmd_seq #(.DEV_SIZE(4096), .MFR_ID(8'h20), .DEV_ID(16'h2014), .EXT_ID(16'h0000)) dut (
        .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_a), .rd_addr(ra_a), .rd_data(rdd_a), .erase_req(er_a), .erase_kind(ek_a),
        .erase_addr(ea_a), .prog_req(pr_a), .prog_addr(pa_a), .prog_data(pd_a));

    flash_cmd_seq #(.DEV_SIZE(4096), .MFR_ID(8'hEF), .DEV_ID(16'h4017), .EXT_ID(16'h4D01)) dut_b (
        .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_b), .rd_addr(ra_b), .rd_data(rdd_b), .erase_req(er_b), .erase_kind(ek_b),
        .erase_addr(ea_b), .prog_req(pr_b), .prog_addr(pa_b), .prog_data(pd_b));

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic cs();
        cs_start = 1'b1;
        @(negedge clk);
        cs_start = 1'b0;
    endtask

    task automatic cs_xfer(input logic [7:0] b);
        cs_start = 1'b1;
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        cs_start = 1'b0;
        rx_valid = 1'b0;
    endtask

    task automatic status(input string req, input logic wel);
        cs();
        xfer(8'h05);
        chk(req, tx_a, 8'h00);
        xfer(8'h00);
        chk(req, tx_a, {6'b0, wel, 1'b0});
    endtask

    initial begin
        logic [7:0] rops [3];
        logic [7:0] pops [3];
        logic [7:0] eops [3];
        logic [23:0] starts [3];
        rops = '{8'h0B, 8'h3B, 8'h6B};
        pops = '{8'h02, 8'hA2, 8'h32};
        eops = '{8'h20, 8'h52, 8'hD8};
        starts = '{24'h000000, 24'h000123, 24'h000FFE};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", tx_a, 8'h00);
        chk("R1", {er_a, pr_a}, 2'b00);
        status("R1", 1'b0);

        // R2: latch set/clear; status byte then back to opcode decode
        cs(); xfer(8'h06);
        chk("R2", tx_a, 8'h00);
        cs(); xfer(8'h05); xfer(8'hFF);
        chk("R2", tx_a, 8'h02);
        xfer(8'h05);
        chk("R2", tx_a, 8'h00);
        xfer(8'h00);
        chk("R2", tx_a, 8'h02);
        cs(); xfer(8'h04);
        status("R2", 1'b0);

        // R3: identification bytes, short and extended
        cs(); xfer(8'h9F);
        xfer(8'h00); chk("R3", tx_a, 8'h20); chk("R3", tx_b, 8'hEF);
        xfer(8'h00); chk("R3", tx_a, 8'h20); chk("R3", tx_b, 8'h40);
        xfer(8'h00); chk("R3", tx_a, 8'h14); chk("R3", tx_b, 8'h17);
        xfer(8'h00); chk("R3", tx_a, 8'h00); chk("R3", tx_b, 8'h4D);
        xfer(8'h00); chk("R3", tx_a, 8'h00); chk("R3", tx_b, 8'h01);
        xfer(8'h05); chk("R3", tx_b, 8'h00);
        xfer(8'h00); chk("R3", tx_b, 8'h00);

        // R4: plain read with wrap at device size
        foreach (starts[s]) begin
            cs(); xfer(8'h03);
            xfer(starts[s][23:16]); xfer(starts[s][15:8]); xfer(starts[s][7:0]);
            chk("R4", tx_a, 8'h00);
            for (int i = 0; i < 4; i++) begin
                xfer(8'h00);
                chk("R4", tx_a, mem((starts[s] + 24'(i)) & 24'hFFF));
            end
        end

        // R5: four collected bytes for fast and multi-output reads
        foreach (rops[k]) begin
            cs(); xfer(rops[k]);
            xfer(8'h00); xfer(8'h04); xfer(8'h56); xfer(8'hAA);
            chk("R5", tx_a, 8'h00);
            xfer(8'h00); chk("R5", tx_a, mem(24'h000456));
            xfer(8'h00); chk("R5", tx_a, mem(24'h000457));
        end

        // R6: dual I/O read dummy count depends on manufacturer
        cs(); xfer(8'hBB);
        xfer(8'h00); xfer(8'h01); xfer(8'h23); xfer(8'h11);
        xfer(8'h22);
        chk("R6", tx_a, 8'h00); chk("R6", tx_b, mem(24'h000123));
        xfer(8'h33);
        chk("R6", tx_a, mem(24'h000123)); chk("R6", tx_b, mem(24'h000124));
        // R6: quad I/O read
        cs(); xfer(8'hEB);
        xfer(8'h00); xfer(8'h02); xfer(8'h00);
        for (int i = 0; i < 5; i++) xfer(8'h77);
        chk("R6", tx_a, 8'h00); chk("R6", tx_b, mem(24'h000201));
        xfer(8'h77);
        chk("R6", tx_a, mem(24'h000200)); chk("R6", tx_b, mem(24'h000202));

        // R7: program variants
        foreach (pops[k]) begin
            logic [23:0] base;
            base = 24'h001020 + 24'(k * 24'h100);
            cs(); xfer(pops[k]);
            xfer(base[23:16]); xfer(base[15:8]); xfer(base[7:0]);
            chk("R7", pr_a, 1'b0);
            for (int i = 0; i < 4; i++) begin
                logic [7:0] dv;
                dv = 8'(8'hD0 + i * 7 + k);
                xfer(dv);
                chk("R7", pr_a, 1'b1);
                chk("R7", pa_a, base + 24'(i));
                chk("R7", pd_a, dv);
                chk("R12", tx_a, 8'h00);
            end
        end
        @(negedge clk);
        chk("R7", pr_a, 1'b0);

        // R8: erase refused with latch clear
        foreach (eops[k]) begin
            cs(); xfer(eops[k]);
            xfer(8'h00); xfer(8'h00); xfer(8'h40);
            chk("R8", er_a, 1'b0);
        end
        cs(); xfer(8'h06);
        foreach (eops[k]) begin
            cs(); xfer(eops[k]);
            xfer(8'h01); xfer(8'h23);
            chk("R8", er_a, 1'b0);
            xfer(8'(8'h45 + k));
            chk("R8", er_a, 1'b1);
            chk("R8", ek_a, (k == 0) ? 2'd0 : (k == 1) ? 2'd1 : 2'd2);
            chk("R8", ea_a, {16'h0123, 8'(8'h45 + k)});
        end

        // R9: bulk erase gated by latch
        cs(); xfer(8'hC7);
        chk("R9", er_a, 1'b1); chk("R9", ek_a, 2'd3); chk("R9", ea_a, 24'h0);
        cs(); xfer(8'h04);
        cs(); xfer(8'hC7);
        chk("R9", er_a, 1'b0);

        // R10: write status ignored with latch clear
        cs(); xfer(8'h01);
        xfer(8'h05); chk("R10", tx_a, 8'h00);
        xfer(8'h00); chk("R10", tx_a, 8'h00);
        // R10: accepted with latch set, then latch cleared
        cs(); xfer(8'h06);
        status("R10", 1'b1);
        cs(); xfer(8'h01);
        xfer(8'h55); chk("R10", tx_a, 8'h00);
        xfer(8'h05); xfer(8'h00);
        chk("R10", tx_a, 8'h00);
        status("R10", 1'b0);

        // R11: chip select aborts a read; same-cycle byte is an opcode
        cs(); xfer(8'h06);
        cs(); xfer(8'h03); xfer(8'h00); xfer(8'h00); xfer(8'h10);
        xfer(8'h00); chk("R11", tx_a, mem(24'h000010));
        cs_xfer(8'h05); chk("R11", tx_a, 8'h00);
        xfer(8'h00); chk("R11", tx_a, 8'h02);
        // R11: chip select aborts identification playback
        cs(); xfer(8'h9F); xfer(8'h00); chk("R11", tx_a, 8'h20);
        cs(); xfer(8'h05); xfer(8'h00); chk("R11", tx_a, 8'h02);

        // R12: unknown opcode and no-op stay idle
        cs(); xfer(8'hAB); chk("R12", tx_a, 8'h00);
        xfer(8'h00); chk("R12", tx_a, 8'h00);
        xfer(8'h05); chk("R12", tx_a, 8'h00);
        xfer(8'h00); chk("R12", tx_a, 8'h02);

        // R13: response holds between transfers
        repeat (3) @(negedge clk);
        chk("R13", tx_a, 8'h02);
        chk("R13", {er_a, pr_a}, 2'b00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule